// File: doc/BRIEF.md
# Event and Gate Counter with Edge-Synchronized Output Enable

This block is an up-counter fed from one external event line. It works in one of two modes. In edge mode, each transition of the line in a chosen direction adds one to the count. In gated mode, an internal tick strobe adds one to the count on each tick, but only while the line sits at a chosen level. The line is asynchronous, so it passes through a synchronizer before the block detects edges or levels.

The count is compared against a programmable limit. When the count reaches the limit and another increment arrives, the count returns to zero and a divided square wave flips. That wave reaches the pin only through an enable. A change to the enable waits for the next active edge of the wave, and a control bit picks which edge is active. The same bit also sets the starting level of the wave whenever software loads the counter.

Top module: `evgate_counter`

## Requirements
- R1: A synchronous active-high reset clears all four control bits (mode, polarity, enable, edge select), the count, the wave, the applied enable and `pin_out`. The limit resets to all ones. `rd_data` reads 0 for the control register after reset.
- R2: The control register is at address 0, with bit0 = mode, bit1 = polarity, bit2 = output enable and bit3 = edge select. The count is at address 1 and the limit at address 2. With mode=0 and polarity=0, each falling edge of `evt_in` adds one to the count. The edge takes effect three clock edges after it is sampled (two synchronizer stages, then the counter).
- R3: With mode=0 and polarity=1, each rising edge of `evt_in` adds one to the count, and a falling edge has no effect.
- R4: With mode=1 and polarity=1, each cycle with `gate_tick` high adds one to the count while the synchronized `evt_in` is high. Ticks have no effect while it is low.
- R5: With mode=1 and polarity=0, ticks count while the synchronized `evt_in` is low, and have no effect while it is high.
- R6: When an increment arrives while the count equals the limit, the count becomes 0 and the wave inverts. The wave period is therefore 2*(limit+1) increments.
- R7: A write to address 1 loads the count and sets the wave to the current edge-select bit. The write takes precedence over an increment in the same cycle.
- R8: `pin_out` is registered. It equals the wave when the applied enable is 1, and it is 0 when the applied enable is 0.
- R9: The applied enable copies the control enable bit only in a cycle that follows an active wave edge. With edge select=0 the active edge is falling, and with edge select=1 it is rising.
- R10: If the enable bit is written again before an active edge, only the newest value is applied.
- R11: In edge mode, `gate_tick` has no effect on the count.
- R12: `rd_data` returns the register at `rd_addr` one cycle later, with the control register zero-extended. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | WIDTH | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | WIDTH | Registered read data |
| gate_tick | input | 1 | Internal counting strobe for gated mode |
| evt_in | input | 1 | Asynchronous external event line |
| pin_out | output | 1 | Gated divided output |

## Verification
The assertions assume three things about the inputs. `gate_tick` is a synchronous single-cycle strobe. Each level of `evt_in` stays long enough for the synchronizer to capture it. Control writes are the only way mode and polarity change. The single-edge property is written to hold only in cycles without a control write. The stimulus keeps every `evt_in` level for at least four clocks, derives ticks from a fixed cycle pattern, and leaves the write strobe low between register accesses. This keeps every increment and enable handoff observable at the pin and through read-back.

// File: rtl/evgate_pkg.sv
package evgate_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_CNT  = 2'd1;
  localparam logic [ADDR_W-1:0] A_LIM  = 2'd2;

  typedef struct packed {
    logic edge_sel;
    logic oe;
    logic pol;
    logic mode;
  } ctrl_t;
endpackage

// File: rtl/evgate_input_cond.sv
module evgate_input_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic evt_in,
  input  logic gate_tick,
  input  logic mode,
  input  logic pol,
  output logic inc
);
  logic [SYNC_STAGES:0] chain;
  logic lvl, prev, rise, fall;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[SYNC_STAGES-1:0], evt_in};
  end

  assign lvl  = chain[SYNC_STAGES-1];
  assign prev = chain[SYNC_STAGES];
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;

  always_comb begin
    if (mode) inc = gate_tick & (lvl == pol);
    else      inc = pol ? rise : fall;
  end
endmodule

// File: rtl/evgate_divider.sv
module evgate_divider #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  input  logic             load_phase,
  input  logic [WIDTH-1:0] limit,
  output logic [WIDTH-1:0] cnt,
  output logic             div
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      div <= 1'b0;
    end else if (load) begin
      cnt <= load_val;
      div <= load_phase;
    end else if (inc) begin
      if (cnt == limit) begin
        cnt <= '0;
        div <= ~div;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/evgate_out_gate.sv
module evgate_out_gate (
  input  logic clk,
  input  logic rst,
  input  logic div,
  input  logic oe_req,
  input  logic edge_sel,
  output logic div_prev,
  output logic en_act,
  output logic pin_out
);
  logic active, en_next;

  assign active  = edge_sel ? (div & ~div_prev) : (~div & div_prev);
  assign en_next = active ? oe_req : en_act;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_prev <= 1'b0;
      en_act   <= 1'b0;
      pin_out  <= 1'b0;
    end else begin
      div_prev <= div;
      en_act   <= en_next;
      pin_out  <= en_next & div;
    end
  end
endmodule

// File: rtl/evgate_counter.sv
module evgate_counter
  import evgate_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [WIDTH-1:0] LIM_RESET = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [WIDTH-1:0]  wr_data,
  input  logic [1:0]        rd_addr,
  output logic [WIDTH-1:0]  rd_data,
  input  logic              gate_tick,
  input  logic              evt_in,
  output logic              pin_out
);
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t            ctrl_q;
  logic [WIDTH-1:0] lim_q;
  logic [WIDTH-1:0] cnt;
  logic             div_q, div_prev, en_act, inc, cnt_wr;

  assign cnt_wr = wr_en && (wr_addr == A_CNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      lim_q  <= LIM_RESET;
    end else if (wr_en) begin
      if (wr_addr == A_CTRL) ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
      if (wr_addr == A_LIM)  lim_q  <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (rd_addr)
        A_CTRL:  rd_data <= {{(WIDTH-CTRL_W){1'b0}}, ctrl_q};
        A_CNT:   rd_data <= cnt;
        A_LIM:   rd_data <= lim_q;
        default: rd_data <= '0;
      endcase
    end
  end

  evgate_input_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
    .clk(clk), .rst(rst), .evt_in(evt_in), .gate_tick(gate_tick),
    .mode(ctrl_q.mode), .pol(ctrl_q.pol), .inc(inc)
  );

  evgate_divider #(.WIDTH(WIDTH)) u_div (
    .clk(clk), .rst(rst), .inc(inc), .load(cnt_wr), .load_val(wr_data),
    .load_phase(ctrl_q.edge_sel), .limit(lim_q), .cnt(cnt), .div(div_q)
  );

  evgate_out_gate u_gate (
    .clk(clk), .rst(rst), .div(div_q), .oe_req(ctrl_q.oe),
    .edge_sel(ctrl_q.edge_sel), .div_prev(div_prev), .en_act(en_act),
    .pin_out(pin_out)
  );
endmodule

// File: rtl/evgate_counter_chk.sv
module evgate_counter_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic [WIDTH-1:0] wr_data,
  input logic             pin_out,
  input logic             inc,
  input logic             mode,
  input logic             edge_sel,
  input logic             div_q,
  input logic             div_prev,
  input logic             en_act,
  input logic [WIDTH-1:0] cnt,
  input logic [WIDTH-1:0] lim_q
);
  logic cnt_wr, ctrl_wr;
  assign cnt_wr  = wr_en && (wr_addr == 2'd1);
  assign ctrl_wr = wr_en && (wr_addr == 2'd0);

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (!pin_out && !en_act && !div_q));

  // R2
  single_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode && inc && !ctrl_wr) |=> !inc);

  // R6
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (inc && !cnt_wr && cnt == lim_q) |=> (cnt == '0 && div_q != $past(div_q)));

  // R7
  load_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_wr |=> (cnt == $past(wr_data) && div_q == $past(edge_sel)));

  // R8
  pin_gate_chk: assert property (@(posedge clk) disable iff (rst)
    pin_out |-> (en_act && $past(div_q)));

  // R9
  en_edge_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(en_act) |-> $past(edge_sel ? (div_q && !div_prev) : (!div_q && div_prev)));
endmodule

bind evgate_counter evgate_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .pin_out(pin_out), .inc(inc), .mode(ctrl_q.mode), .edge_sel(ctrl_q.edge_sel),
  .div_q(div_q), .div_prev(div_prev), .en_act(en_act), .cnt(cnt), .lim_q(lim_q)
);

// File: tb/evgate_counter_bench.sv
module evgate_counter_bench;
  localparam int W = 8;

  logic clk = 0, rst = 1, wr_en = 0, gate_tick = 0, evt_in = 0;
  logic [1:0] wr_addr = 0, rd_addr = 0;
  logic [W-1:0] wr_data = 0;
  logic [W-1:0] rd_data;
  logic pin_out;

  int vectors = 0, miscompares = 0;
  string tag = "R1";
  bit started = 0;

  always #2 clk = ~clk;

  evgate_counter #(.WIDTH(W)) u_evgate_counter (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .gate_tick(gate_tick),
    .evt_in(evt_in), .pin_out(pin_out)
  );

  // behavioural reference model
  int m_s1, m_s2, m_s3, m_cnt, m_lim, m_rd;
  int m_mode, m_pol, m_oe, m_es, m_div, m_dprev, m_en, m_pin;

  always @(posedge clk) begin
    if (rst) begin
      started = 1;
      m_s1 = 0; m_s2 = 0; m_s3 = 0; m_cnt = 0; m_lim = 255; m_rd = 0;
      m_mode = 0; m_pol = 0; m_oe = 0; m_es = 0;
      m_div = 0; m_dprev = 0; m_en = 0; m_pin = 0;
    end else begin
      int bump, act, en_n, rd_n, ctrl;
      if (m_mode != 0) bump = (gate_tick && (m_s2 == m_pol)) ? 1 : 0;
      else if (m_pol != 0) bump = (m_s2 == 1 && m_s3 == 0) ? 1 : 0;
      else bump = (m_s2 == 0 && m_s3 == 1) ? 1 : 0;
      if (m_es != 0) act = (m_div == 1 && m_dprev == 0) ? 1 : 0;
      else act = (m_div == 0 && m_dprev == 1) ? 1 : 0;
      en_n = act ? m_oe : m_en;
      ctrl = m_mode + 2 * m_pol + 4 * m_oe + 8 * m_es;
      case (rd_addr)
        0: rd_n = ctrl;
        1: rd_n = m_cnt;
        2: rd_n = m_lim;
        default: rd_n = 0;
      endcase
      m_pin = en_n & m_dprev_fix(m_div);
      m_dprev = m_div;
      m_en = en_n;
      m_rd = rd_n;
      if (wr_en && wr_addr == 1) begin
        m_cnt = wr_data; m_div = m_es;
      end else if (bump) begin
        if (m_cnt == m_lim) begin m_cnt = 0; m_div = 1 - m_div; end
        else m_cnt = m_cnt + 1;
      end
      if (wr_en && wr_addr == 0) begin
        m_mode = wr_data[0]; m_pol = wr_data[1]; m_oe = wr_data[2]; m_es = wr_data[3];
      end
      if (wr_en && wr_addr == 2) m_lim = wr_data;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = evt_in;
    end
  end

  function automatic int m_dprev_fix(int v);
    return v;
  endfunction

  always @(negedge clk) begin
    if (started) begin
      vectors++;
      if (pin_out !== m_pin[0]) begin
        miscompares++;
        $display("FAIL %s pin_out actual=%0b expected=%0d at %0t", tag, pin_out, m_pin, $time);
      end
      vectors++;
      if (rd_data !== m_rd[W-1:0]) begin
        miscompares++;
        $display("FAIL %s rd_data(addr %0d) actual=%0d expected=%0d at %0t",
                 tag, rd_addr, rd_data, m_rd, $time);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic toggles(input int n, input int hold);
    for (int i = 0; i < n; i++) begin
      evt_in = ~evt_in;
      repeat (hold) @(negedge clk);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); gate_tick = (i % 3 != 1);
    end
    @(negedge clk); gate_tick = 0;
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog timeout actual=hung expected=complete");
    finish_run();
  end

  initial begin
    tag = "R1"; rst = 1;
    repeat (4) @(negedge clk);
    rst = 0; rd_addr = 0;
    repeat (3) @(negedge clk);
    tag = "R12"; rd_addr = 2; repeat (2) @(negedge clk);
    rd_addr = 3; repeat (2) @(negedge clk);

    tag = "R2"; rd_addr = 1; wr(0, 8'h00); wr(2, 8'd9);
    toggles(10, 5);
    tag = "R3"; wr(0, 8'h02); toggles(12, 4);
    tag = "R11"; ticks(20);
    tag = "R4"; evt_in = 1; wr(0, 8'h03); repeat (4) @(negedge clk); ticks(25);
    evt_in = 0; repeat (4) @(negedge clk); ticks(15);
    tag = "R5"; wr(0, 8'h01); ticks(25);
    evt_in = 1; repeat (4) @(negedge clk); ticks(15);

    tag = "R6"; wr(2, 8'd3); wr(1, 8'd0); wr(0, 8'h03); ticks(60);
    tag = "R8"; wr(0, 8'h07); ticks(60);
    tag = "R9"; wr(0, 8'h0F); ticks(40);
    wr(0, 8'h0B); ticks(40);
    wr(0, 8'h03); ticks(30);
    tag = "R10"; wr(0, 8'h07); wr(0, 8'h03); ticks(40);
    wr(0, 8'h03); wr(0, 8'h07); ticks(40);
    tag = "R7"; wr(0, 8'h0F); wr(1, 8'd2); ticks(20);
    @(negedge clk); gate_tick = 1; wr_en = 1; wr_addr = 1; wr_data = 8'd1;
    @(negedge clk); wr_en = 0; gate_tick = 0;
    wr(0, 8'h07); wr(1, 8'd3); ticks(30);
    tag = "R12"; rd_addr = 0; repeat (3) @(negedge clk);
    rd_addr = 2; repeat (3) @(negedge clk);
    tag = "R1"; rst = 1; repeat (3) @(negedge clk); rst = 0;
    rd_addr = 0; repeat (3) @(negedge clk);
    finish_run();
  end
endmodule